// File: doc/BRIEF.md
# Black-Level Clamp Loop Controller

This block is the digital half of a black-level feedback loop for an image-sensor signal chain. Each line carries a run of shielded pixels, and a window pulse marks them. While that pulse is high, the block takes the difference between a programmable black target and each converted sample. It sums these differences in a saturating accumulator. When the window closes, the sum is scaled down by a programmable right shift and added to a correction word. That word drives an offset DAC in front of the converter, so the black level settles at the target over a number of lines.

The correction can be applied on every line or only on every Nth line. It saturates at the DAC code limits. The DAC code never moves while the window is open, so a measurement never sees an offset step. When the loop is switched off, the clamped target itself is driven to the DAC as a fixed offset, and the loop state is frozen until the loop is switched back on.

Top module: `black_clamp_ctrl`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `dac_o` and the internal correction word hold the mid-scale code 2^(DAC_W-1) (128 by default).
- R2: An error term (target minus sample) is added for every rising clock edge that sees `window_i` high. The first edge of each window starts a fresh sum, so the previous window's sum is discarded.
- R3: When a window closes (the first rising edge that sees `window_i` low after it was high), the correction becomes correction + floor(sum / 2^`shift_i`), using an arithmetic right shift. The new code appears on `dac_o` after the next rising edge.
- R4: The correction saturates at 0 and 2^DAC_W-1 (255 by default) and does not wrap.
- R5: The sum saturates at the signed limits of ACC_W = SAMPLE_W+1+WIN_W bits (-65536 and 65535 by default) and does not wrap.
- R6: The target is `level_i` limited to LEVEL_MAX (64 by default). Higher settings act as LEVEL_MAX.
- R7: With `rate_i` = N, the correction is applied on the Nth enabled window close after the last application, and the count then restarts. A value of 0 behaves as 1.
- R8: With `en_i` low, `dac_o` takes the limited target, zero-extended, and the correction and the line count stay frozen. When the loop is enabled again, `dac_o` returns to the held correction.
- R9: `dac_o` is loaded only on rising edges that see `window_i` low. It does not change during a window.
- R10: With the loop enabled and no window close two edges earlier, `dac_o` stays constant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | SAMPLE_W | Converter sample, unsigned |
| window_i | input | 1 | High on shielded (black) pixels |
| level_i | input | LEVEL_W | Black target setting |
| en_i | input | 1 | Loop enable; when low the target is a static offset |
| rate_i | input | RATE_W | Apply correction every N lines (0 acts as 1) |
| shift_i | input | SHIFT_W | Right-shift applied to the window sum |
| dac_o | output | DAC_W | Registered offset DAC code |

## Verification
A window close is seen on one rising edge, and the correction updates on that same edge. `dac_o` follows one edge later. The bench therefore drops `window_i` at a falling edge, lets two rising edges pass, and compares `dac_o` at the next falling edge with a value its own model computes. A change in the enable or the target reaches `dac_o` on the first rising edge with the window low, so the bench lets two idle cycles pass after every configuration change before a window starts. It also compares `dac_o` at each falling edge inside a window with its value just before the window opened.

// File: rtl/bclamp_pkg.sv
package bclamp_pkg;
  typedef struct packed {
    logic open;
    logic close;
    logic active;
  } win_evt_t;
endpackage

// File: rtl/bclamp_win_track.sv
module bclamp_win_track
  import bclamp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     window_i,
  output win_evt_t evt_o
);
  logic win_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) win_q <= 1'b0;
    else         win_q <= window_i;
  end

  always_comb begin
    evt_o.open   = window_i & ~win_q;
    evt_o.close  = ~window_i & win_q;
    evt_o.active = window_i;
  end
endmodule

// File: rtl/bclamp_err_acc.sv
module bclamp_err_acc
  import bclamp_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = 17
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  win_evt_t                evt_i,
  input  logic [SAMPLE_W-1:0]     sample_i,
  input  logic [SAMPLE_W-1:0]     ref_i,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int ERR_W = SAMPLE_W + 1;
  localparam logic signed [ACC_W:0] ACC_HI = $signed({2'b00, {(ACC_W-1){1'b1}}});
  localparam logic signed [ACC_W:0] ACC_LO = $signed({2'b11, {(ACC_W-1){1'b0}}});

  logic signed [ERR_W-1:0] err;
  logic signed [ACC_W:0]   err_x, base_x, sum;
  logic signed [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    err    = $signed({1'b0, ref_i}) - $signed({1'b0, sample_i});
    err_x  = {{(ACC_W+1-ERR_W){err[ERR_W-1]}}, err};
    base_x = evt_i.open ? '0 : {acc_q[ACC_W-1], acc_q};
    sum    = base_x + err_x;
    if (sum > ACC_HI)      acc_d = ACC_HI[ACC_W-1:0];
    else if (sum < ACC_LO) acc_d = ACC_LO[ACC_W-1:0];
    else                   acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           acc_q <= '0;
    else if (evt_i.active) acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/bclamp_rate_gate.sv
module bclamp_rate_gate
  import bclamp_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  win_evt_t          evt_i,
  input  logic              en_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              apply_o
);
  logic [RATE_W-1:0] cnt_q, last_idx;
  logic              hit, step;

  always_comb begin
    last_idx = (rate_i == '0) ? '0 : rate_i - 1'b1;
    hit      = cnt_q >= last_idx;
    step     = evt_i.close & en_i;
    apply_o  = step & hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_q <= '0;
    else if (step) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bclamp_corr_reg.sv
module bclamp_corr_reg #(
  parameter int ACC_W   = 17,
  parameter int DAC_W   = 8,
  parameter int SHIFT_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    apply_i,
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [SHIFT_W-1:0]      shift_i,
  output logic [DAC_W-1:0]        corr_o
);
  localparam logic [DAC_W-1:0]      CORR_MID = DAC_W'(1) << (DAC_W-1);
  localparam logic signed [ACC_W:0] CODE_HI  = $signed({{(ACC_W+1-DAC_W){1'b0}}, {DAC_W{1'b1}}});

  logic signed [ACC_W-1:0] delta;
  logic signed [ACC_W:0]   sum;
  logic [DAC_W-1:0]        corr_q, corr_d;

  always_comb begin
    delta = acc_i >>> shift_i;
    sum   = $signed({{(ACC_W+1-DAC_W){1'b0}}, corr_q}) + {delta[ACC_W-1], delta};
    if (sum < 0)            corr_d = '0;
    else if (sum > CODE_HI) corr_d = '1;
    else                    corr_d = sum[DAC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      corr_q <= CORR_MID;
    else if (apply_i) corr_q <= corr_d;
  end

  assign corr_o = corr_q;
endmodule

// File: rtl/black_clamp_ctrl.sv
module black_clamp_ctrl
  import bclamp_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int LEVEL_W   = 8,
  parameter int LEVEL_MAX = 64,
  parameter int DAC_W     = 8,
  parameter int WIN_W     = 6,
  parameter int RATE_W    = 4,
  parameter int SHIFT_W   = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic                window_i,
  input  logic [LEVEL_W-1:0]  level_i,
  input  logic                en_i,
  input  logic [RATE_W-1:0]   rate_i,
  input  logic [SHIFT_W-1:0]  shift_i,
  output logic [DAC_W-1:0]    dac_o
);
  localparam int               ACC_W   = SAMPLE_W + 1 + WIN_W;
  localparam logic [DAC_W-1:0] DAC_MID = DAC_W'(1) << (DAC_W-1);

  win_evt_t                evt;
  logic [LEVEL_W-1:0]      lvl_ref;
  logic signed [ACC_W-1:0] acc;
  logic                    apply;
  logic [DAC_W-1:0]        corr, dac_q;

  if (LEVEL_MAX >= (1 << LEVEL_W) - 1) begin : g_lvl_full
    assign lvl_ref = level_i;
  end else begin : g_lvl_limit
    assign lvl_ref = (level_i > LEVEL_W'(LEVEL_MAX)) ? LEVEL_W'(LEVEL_MAX) : level_i;
  end

  bclamp_win_track u_win (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .window_i(window_i),
    .evt_o   (evt)
  );

  bclamp_err_acc #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .evt_i   (evt),
    .sample_i(sample_i),
    .ref_i   (SAMPLE_W'(lvl_ref)),
    .acc_o   (acc)
  );

  bclamp_rate_gate #(.RATE_W(RATE_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .evt_i  (evt),
    .en_i   (en_i),
    .rate_i (rate_i),
    .apply_o(apply)
  );

  bclamp_corr_reg #(.ACC_W(ACC_W), .DAC_W(DAC_W), .SHIFT_W(SHIFT_W)) u_corr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .apply_i(apply),
    .acc_i  (acc),
    .shift_i(shift_i),
    .corr_o (corr)
  );

  // DAC never moves while black pixels are measured
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          dac_q <= DAC_MID;
    else if (!evt.active) dac_q <= en_i ? corr : DAC_W'(lvl_ref);
  end

  assign dac_o = dac_q;
endmodule

// File: rtl/bclamp_ctrl_chk.sv
module bclamp_ctrl_chk #(
  parameter int LEVEL_W   = 8,
  parameter int LEVEL_MAX = 64,
  parameter int DAC_W     = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               window_i,
  input logic [LEVEL_W-1:0] level_i,
  input logic               en_i,
  input logic [DAC_W-1:0]   dac_o
);
  localparam logic [DAC_W-1:0] MID = DAC_W'(1) << (DAC_W-1);
  logic [DAC_W-1:0] tgt;

  always_comb tgt = (int'(level_i) > LEVEL_MAX) ? DAC_W'(LEVEL_MAX) : DAC_W'(level_i);

  always @(posedge clk_i) begin
    if (!rst_ni) AST_RESET_MIDSCALE: assert (dac_o == MID); // R1
  end

  AST_HOLD_IN_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    window_i |=> $stable(dac_o)); // R9

  AST_DISABLED_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !window_i) |=> (dac_o == $past(tgt))); // R8

  AST_QUIET_BETWEEN_WINDOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !window_i && $past(en_i) && !$past(window_i) && !$past(window_i, 2))
    |=> $stable(dac_o)); // R10
endmodule

bind black_clamp_ctrl bclamp_ctrl_chk #(
  .LEVEL_W(LEVEL_W), .LEVEL_MAX(LEVEL_MAX), .DAC_W(DAC_W)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .window_i(window_i),
  .level_i (level_i),
  .en_i    (en_i),
  .dac_o   (dac_o)
);

// File: tb/black_clamp_ctrl_bench.sv
module black_clamp_ctrl_bench;
  localparam int ACC_HI = 65535;
  localparam int ACC_LO = -65536;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [9:0] sample_i = '0;
  logic       window_i = 1'b0;
  logic [7:0] level_i = '0;
  logic       en_i = 1'b1;
  logic [3:0] rate_i = 4'd1;
  logic [3:0] shift_i = '0;
  logic [7:0] dac_o;

  int checks = 0, errors = 0;
  int m_corr = 128, m_cnt = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  black_clamp_ctrl u_black_clamp_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .window_i(window_i),
    .level_i(level_i), .en_i(en_i), .rate_i(rate_i), .shift_i(shift_i), .dac_o(dac_o)
  );

  function automatic int f_ref(int lvl);
    return (lvl > 64) ? 64 : lvl;
  endfunction

  function automatic int f_acc(int a, int e);
    int s = a + e;
    if (s > ACC_HI) return ACC_HI;
    if (s < ACC_LO) return ACC_LO;
    return s;
  endfunction

  function automatic int f_corr(int c, int a, int sh);
    int n = c + (a >>> sh);
    if (n < 0) return 0;
    if (n > 255) return 255;
    return n;
  endfunction

  function automatic int f_dac();
    return en_i ? m_corr : f_ref(int'(level_i));
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: dac_o=%0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic set_cfg(bit en, int lvl, int rate, int sh);
    @(negedge clk_i);
    en_i = en; level_i = 8'(lvl); rate_i = 4'(rate); shift_i = 4'(sh);
    repeat (2) @(negedge clk_i);
  endtask

  // one line: window of len cycles, samples base +/- dev, then check
  task automatic run_line(string tag, int len, int base, int dev);
    int acc = 0;
    int pre;
    bit moved = 0;
    int eff;
    @(negedge clk_i);
    pre = int'(dac_o);
    for (int i = 0; i < len; i++) begin
      int s;
      if (i > 0 && int'(dac_o) != pre) moved = 1;
      s = base + ((dev > 0) ? (int'($urandom_range(2*dev)) - dev) : 0);
      if (s < 0) s = 0;
      if (s > 1023) s = 1023;
      window_i = 1'b1;
      sample_i = 10'(s);
      acc = f_acc(acc, f_ref(int'(level_i)) - s);
      @(negedge clk_i);
    end
    if (int'(dac_o) != pre) moved = 1;
    window_i = 1'b0;
    chk("R9 dac stable in window", moved ? -1 : pre, pre);
    if (en_i) begin
      eff = (rate_i == 0) ? 1 : int'(rate_i);
      if (m_cnt >= eff - 1) begin
        m_corr = f_corr(m_corr, acc, int'(shift_i));
        m_cnt = 0;
      end else m_cnt++;
    end
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag, int'(dac_o), f_dac());
    repeat (2) @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog: run hung, dac_o=%0d expected completion", dac_o);
    finish_run();
  end

  initial begin
    void'($urandom(32'h1c3a5));
    #1 rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R1 reset value", int'(dac_o), 128);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R1 after release", int'(dac_o), 128);

    // R2 R3: loop tracking with noisy samples, fresh sum per window
    set_cfg(1, 32, 1, 3);
    for (int k = 0; k < 16; k++)
      run_line("R2 R3 window update", 20 + int'($urandom_range(20)), 30 + int'($urandom_range(8)), 25);

    // R4: saturate high then low
    set_cfg(1, 64, 1, 0);
    run_line("R4 saturate max", 30, 0, 0);
    chk("R4 max code", int'(dac_o), 255);
    run_line("R4 saturate min", 30, 1023, 0);
    chk("R4 min code", int'(dac_o), 0);

    // R5: sum limit at +65535 -> +1 after >>15
    set_cfg(1, 64, 1, 15);
    run_line("R5 sum saturates high", 1100, 0, 0);
    chk("R5 high limit result", int'(dac_o), 1);
    set_cfg(1, 0, 1, 15);
    run_line("R5 sum saturates low", 80, 1023, 0);

    // R6: setting above limit acts as 64
    set_cfg(1, 200, 1, 0);
    run_line("R6 target limited", 25, 64, 0);
    run_line("R6 target limited below", 10, 60, 0);

    // R7: every third line, then rate 0 as every line
    set_cfg(1, 20, 3, 2);
    for (int k = 0; k < 7; k++) run_line("R7 rate three", 24, 14, 4);
    set_cfg(1, 20, 0, 2);
    for (int k = 0; k < 3; k++) run_line("R7 rate zero", 24, 26, 4);

    // R8: disabled static offset, frozen loop, return on enable
    set_cfg(0, 40, 1, 0);
    chk("R8 disabled offset", int'(dac_o), 40);
    run_line("R8 disabled window ignored", 30, 0, 0);
    set_cfg(0, 250, 1, 0);
    chk("R8 disabled limited", int'(dac_o), 64);
    set_cfg(1, 40, 1, 0);
    chk("R8 restore correction", int'(dac_o), m_corr);

    // R10 and mixed random configurations
    for (int k = 0; k < 30; k++) begin
      int pre;
      set_cfg(bit'($urandom_range(3) != 0), int'($urandom_range(80)),
              int'($urandom_range(3)), int'($urandom_range(6)));
      pre = int'(dac_o);
      repeat (3) @(negedge clk_i);
      chk("R10 quiet without window", int'(dac_o), pre);
      run_line("R3 R7 R8 random mix", 20 + int'($urandom_range(15)),
               int'($urandom_range(80)), int'($urandom_range(20)));
    end

    finish_run();
  end
endmodule